// File: doc/BRIEF.md
# Dual Page Buffer Engine

This block holds two page-sized byte buffers, A and B, and serves commands passed on by a serial command framer. The framer hands over one decoded command at a time: an 8-bit opcode and the three address bytes that followed it. After a write opcode, data bytes arrive on a write stream and are stored into the chosen buffer. After a read opcode, bytes from the chosen buffer leave on a read stream. In both cases a byte pointer starts at the decoded start address, advances once per byte, and wraps to 0 after the last byte of the page. When the framer sees chip select rise, it pulses `cmd_end`, which ends an open write or read.

A transfer port links the block to a flash-array model. A load opcode takes in exactly one page on the load stream and places it in a buffer from byte 0 up. A store opcode sends one whole buffer out on the store stream. While either transfer runs, `xfer_page` shows the page number decoded from the address bytes. Direct array reads and every other opcode are accepted and then dropped, and neither buffer changes.

A single mode input picks a 528-byte page or a binary 512-byte page. The mode sets the address bits that form the start address and the page number, and it sets the wrap point. Every data port is valid/ready. A byte moves only in a cycle where valid and ready are both high. A producer holds valid and data steady until that cycle. A consumer may hold ready low for as long as it likes, and the block then keeps its valid and data unchanged.

Top module: `dpb_engine`

## Requirements
- R1: Opcode 84h opens a write into buffer A and 87h opens a write into buffer B. Each accepted write-stream byte is stored at the pointer, and the pointer then advances.
- R2: Opcodes D1h (A) and D3h (B) stream read data out starting the cycle after the command is accepted. Opcodes D4h (A) and D6h (B) first take one discarded dummy byte on the write stream, and `rd_valid` stays low until that byte is accepted.
- R3: With `page_528`=1, the start address is `cmd_addr[9:0]`; a value of 528 or more has 528 subtracted, and bits 23..10 are ignored. With `page_528`=0, the start address is `cmd_addr[8:0]`, and bits 23..9 are ignored.
- R4: After the last byte (527 in 528-byte mode, 511 in 512-byte mode) the pointer wraps to 0. The pointer never points past the page.
- R5: Opcodes 53h (A) and 55h (B) accept exactly one page of bytes on the load stream into indices 0 and up. The other buffer is left unchanged. `busy` stays high and `cmd_end` is ignored until the last byte is accepted. `xfer_page` equals `cmd_addr[21:10]` in 528-byte mode and `cmd_addr[20:9]` in 512-byte mode, and it holds through the transfer.
- R6: Opcodes 83h (A) and 86h (B) emit one whole page on the store stream, from index 0 to the last byte, and then return to idle.
- R7: Any other opcode (for example D2h, E8h, 03h, 0Bh) is accepted. It leaves both buffers unchanged, and the block is idle again in the next cycle.
- R8: `cmd_ready` is high only when the block is idle. A `cmd_end` pulse during a write, dummy or read phase returns the block to idle in the next cycle. At most one of `wr_ready`, `rd_valid`, `ld_ready`, `st_valid` is high at a time.
- R9: After reset, `cmd_ready`=1 and `busy`, `wr_ready`, `rd_valid`, `ld_ready` and `st_valid` are all 0.
- R10: While `rd_valid` or `st_valid` is high and its ready is low, the valid stays high and the data stays stable in the next cycle. For the read stream this holds only if no `cmd_end` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_528 | input | 1 | 1: 528-byte page, 0: 512-byte page; sampled when a command is accepted |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 24 | The three address bytes, first byte in bits 23..16 |
| cmd_end | input | 1 | One-cycle pulse: chip select released |
| wr_valid | input | 1 | Write/dummy byte offered |
| wr_ready | output | 1 | Write/dummy byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| ld_valid | input | 1 | Page-load byte offered by the array model |
| ld_ready | output | 1 | Page-load byte accepted |
| ld_data | input | 8 | Page-load byte |
| st_valid | output | 1 | Page-store byte offered to the array model |
| st_ready | input | 1 | Page-store byte taken |
| st_data | output | 8 | Page-store byte |
| xfer_page | output | 12 | Page number of the current transfer |
| busy | output | 1 | A command is in progress |

## Verification
The assertions assume the framer pulses `cmd_end` only between commands or during a write or read phase. They also assume that `page_528` matters only at command acceptance, and that every producer holds valid and data until the byte is accepted. The stimulus meets these assumptions: each handshake task raises valid at a falling edge and keeps it up until ready has been seen. The bench changes the mode only while the block is idle, and the one `cmd_end` it sends during a page load is there to show that the pulse is ignored.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  localparam logic [7:0] OPC_WR_A      = 8'h84;
  localparam logic [7:0] OPC_WR_B      = 8'h87;
  localparam logic [7:0] OPC_RD_SLOW_A = 8'hD1;
  localparam logic [7:0] OPC_RD_SLOW_B = 8'hD3;
  localparam logic [7:0] OPC_RD_FAST_A = 8'hD4;
  localparam logic [7:0] OPC_RD_FAST_B = 8'hD6;
  localparam logic [7:0] OPC_LOAD_A    = 8'h53;
  localparam logic [7:0] OPC_LOAD_B    = 8'h55;
  localparam logic [7:0] OPC_STORE_A   = 8'h83;
  localparam logic [7:0] OPC_STORE_B   = 8'h86;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_READ_SLOW,
    OP_READ_FAST,
    OP_LOAD,
    OP_STORE
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_DUMMY,
    ST_READ,
    ST_LOAD,
    ST_STORE
  } state_e;

  typedef struct packed {
    op_kind_e kind;
    logic     buf_b;
  } op_dec_t;

endpackage

// File: rtl/dpb_cmd_decode.sv
module dpb_cmd_decode
  import dpb_pkg::*;
#(
  parameter int ADDR_IN_W = 24,
  parameter int PAGE_STD  = 528,
  parameter int ADDR_W    = 10,
  parameter int BIN_W     = 9,
  parameter int PG_W      = 12
) (
  input  logic [7:0]           opcode,
  input  logic [ADDR_IN_W-1:0] addr,
  input  logic                 page_528,
  output op_dec_t              dec,
  output logic [ADDR_W-1:0]    start,
  output logic [PG_W-1:0]      page
);

  localparam logic [ADDR_W-1:0] STD_L = ADDR_W'(PAGE_STD);

  logic [ADDR_W-1:0] raw_std;
  logic [ADDR_W-1:0] raw_bin;
  logic              unused_hi;

  assign unused_hi = ^addr[ADDR_IN_W-1:ADDR_W+PG_W];
  assign raw_std   = addr[ADDR_W-1:0];
  assign raw_bin   = {{(ADDR_W-BIN_W){1'b0}}, addr[BIN_W-1:0]};

  always_comb begin
    dec.kind  = OP_NONE;
    dec.buf_b = 1'b0;
    case (opcode)
      OPC_WR_A:      dec.kind = OP_WRITE;
      OPC_WR_B:      begin dec.kind = OP_WRITE;     dec.buf_b = 1'b1; end
      OPC_RD_SLOW_A: dec.kind = OP_READ_SLOW;
      OPC_RD_SLOW_B: begin dec.kind = OP_READ_SLOW; dec.buf_b = 1'b1; end
      OPC_RD_FAST_A: dec.kind = OP_READ_FAST;
      OPC_RD_FAST_B: begin dec.kind = OP_READ_FAST; dec.buf_b = 1'b1; end
      OPC_LOAD_A:    dec.kind = OP_LOAD;
      OPC_LOAD_B:    begin dec.kind = OP_LOAD;      dec.buf_b = 1'b1; end
      OPC_STORE_A:   dec.kind = OP_STORE;
      OPC_STORE_B:   begin dec.kind = OP_STORE;     dec.buf_b = 1'b1; end
      default:       dec.kind = OP_NONE;
    endcase
  end

  always_comb begin
    if (page_528) begin
      start = (raw_std >= STD_L) ? (raw_std - STD_L) : raw_std;
      page  = addr[ADDR_W +: PG_W];
    end else begin
      start = raw_bin;
      page  = addr[BIN_W +: PG_W];
    end
  end

endmodule

// File: rtl/dpb_ptr.sv
module dpb_ptr #(
  parameter int PAGE_STD = 528,
  parameter int PAGE_BIN = 512,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              mode_528,
  output logic [ADDR_W-1:0] ptr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_STD = ADDR_W'(PAGE_STD - 1);
  localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(PAGE_BIN - 1);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] last;

  assign last    = mode_528 ? LAST_STD : LAST_BIN;
  assign at_last = (ptr_q == last);
  assign ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (step) begin
      ptr_q <= at_last ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/dpb_bufmem.sv
module dpb_bufmem #(
  parameter int DEPTH  = 528,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/dpb_engine.sv
module dpb_engine
  import dpb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_IN_W = 24,
  parameter int PAGE_STD  = 528,
  parameter int PAGE_BIN  = 512,
  parameter int PG_W      = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 page_528,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_opcode,
  input  logic [ADDR_IN_W-1:0] cmd_addr,
  input  logic                 cmd_end,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [DATA_W-1:0]    ld_data,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [DATA_W-1:0]    st_data,
  output logic [PG_W-1:0]      xfer_page,
  output logic                 busy
);

  localparam int ADDR_W = $clog2(PAGE_STD);
  localparam int BIN_W  = $clog2(PAGE_BIN);
  localparam int NBUF   = 2;

  state_e            state_q, state_d;
  logic              sel_q;
  logic              mode_q;
  logic [PG_W-1:0]   page_q;

  op_dec_t           dec;
  logic [ADDR_W-1:0] dec_start;
  logic [PG_W-1:0]   dec_page;

  logic              cmd_fire, wr_fire, rd_fire, ld_fire, st_fire;
  logic              ptr_load, ptr_step, at_last;
  logic [ADDR_W-1:0] ptr, ptr_init;
  logic              mem_wr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] buf_rdata [NBUF];
  logic [DATA_W-1:0] sel_rdata;

  dpb_cmd_decode #(
    .ADDR_IN_W(ADDR_IN_W), .PAGE_STD(PAGE_STD),
    .ADDR_W(ADDR_W), .BIN_W(BIN_W), .PG_W(PG_W)
  ) u_dec (
    .opcode(cmd_opcode), .addr(cmd_addr), .page_528(page_528),
    .dec(dec), .start(dec_start), .page(dec_page)
  );

  // handshakes
  assign cmd_ready = (state_q == ST_IDLE);
  assign wr_ready  = (state_q == ST_WRITE) || (state_q == ST_DUMMY);
  assign rd_valid  = (state_q == ST_READ);
  assign ld_ready  = (state_q == ST_LOAD);
  assign st_valid  = (state_q == ST_STORE);
  assign busy      = (state_q != ST_IDLE);

  assign cmd_fire = cmd_valid && cmd_ready;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign ld_fire  = ld_valid && ld_ready;
  assign st_fire  = st_valid && st_ready;

  // pointer control: transfers always start at byte 0
  assign ptr_load = cmd_fire;
  assign ptr_init = (dec.kind == OP_LOAD || dec.kind == OP_STORE) ? '0 : dec_start;
  assign ptr_step = (wr_fire && state_q == ST_WRITE) || rd_fire || ld_fire || st_fire;

  dpb_ptr #(
    .PAGE_STD(PAGE_STD), .PAGE_BIN(PAGE_BIN), .ADDR_W(ADDR_W)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_init),
    .step(ptr_step), .mode_528(mode_q), .ptr(ptr), .at_last(at_last)
  );

  assign mem_wr    = (wr_fire && state_q == ST_WRITE) || ld_fire;
  assign mem_wdata = (state_q == ST_LOAD) ? ld_data : wr_data;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic we_g;
    assign we_g = mem_wr && (sel_q == g[0]);
    dpb_bufmem #(
      .DEPTH(PAGE_STD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_mem (
      .clk(clk), .we(we_g), .addr(ptr), .wdata(mem_wdata), .rdata(buf_rdata[g])
    );
  end

  assign sel_rdata = buf_rdata[sel_q];
  assign rd_data   = sel_rdata;
  assign st_data   = sel_rdata;
  assign xfer_page = page_q;

  // sequencing
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          case (dec.kind)
            OP_WRITE:     state_d = ST_WRITE;
            OP_READ_SLOW: state_d = ST_READ;
            OP_READ_FAST: state_d = ST_DUMMY;
            OP_LOAD:      state_d = ST_LOAD;
            OP_STORE:     state_d = ST_STORE;
            default:      state_d = ST_IDLE;
          endcase
        end
      end
      ST_WRITE: if (cmd_end) state_d = ST_IDLE;
      ST_DUMMY: begin
        if (cmd_end)      state_d = ST_IDLE;
        else if (wr_fire) state_d = ST_READ;
      end
      ST_READ:  if (cmd_end) state_d = ST_IDLE;
      ST_LOAD:  if (ld_fire && at_last) state_d = ST_IDLE;
      ST_STORE: if (st_fire && at_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      mode_q  <= 1'b1;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_fire) begin
        sel_q  <= dec.buf_b;
        mode_q <= page_528;
        if (dec.kind == OP_LOAD || dec.kind == OP_STORE) page_q <= dec_page;
      end
    end
  end

endmodule

// File: rtl/dpb_engine_chk.sv
module dpb_engine_chk
  import dpb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 10,
  parameter int PG_W     = 12,
  parameter int PAGE_STD = 528,
  parameter int PAGE_BIN = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic              cmd_end,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              ld_ready,
  input logic              st_valid,
  input logic              st_ready,
  input logic [DATA_W-1:0] st_data,
  input logic [PG_W-1:0]   xfer_page,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              mode_528
);

  logic fire, is_load, is_slow, is_fast, is_known;
  assign fire     = cmd_valid && cmd_ready;
  assign is_load  = (cmd_opcode == OPC_LOAD_A) || (cmd_opcode == OPC_LOAD_B);
  assign is_slow  = (cmd_opcode == OPC_RD_SLOW_A) || (cmd_opcode == OPC_RD_SLOW_B);
  assign is_fast  = (cmd_opcode == OPC_RD_FAST_A) || (cmd_opcode == OPC_RD_FAST_B);
  assign is_known = is_load || is_slow || is_fast ||
                    (cmd_opcode == OPC_WR_A) || (cmd_opcode == OPC_WR_B) ||
                    (cmd_opcode == OPC_STORE_A) || (cmd_opcode == OPC_STORE_B);

  assert_slow_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_slow |=> rd_valid);

  assert_fast_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_fast |=> !rd_valid && wr_ready);

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_528 ? (ptr < ADDR_W'(PAGE_STD)) : (ptr < ADDR_W'(PAGE_BIN)));

  assert_load_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_load |=> ld_ready && busy);

  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready || st_valid) |=> $stable(xfer_page));

  assert_nop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !is_known |=> cmd_ready && !busy);

  assert_one_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ready, rd_valid, ld_ready, st_valid}));

  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end && (wr_ready || rd_valid) |=> cmd_ready);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !cmd_end |=> rd_valid && $stable(rd_data));

  assert_st_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data));

endmodule

bind dpb_engine dpb_engine_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PG_W(PG_W),
  .PAGE_STD(PAGE_STD), .PAGE_BIN(PAGE_BIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_opcode(cmd_opcode), .cmd_end(cmd_end), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .ld_ready(ld_ready), .st_valid(st_valid), .st_ready(st_ready),
  .st_data(st_data), .xfer_page(xfer_page), .busy(busy),
  .ptr(ptr), .mode_528(mode_q)
);

// File: tb/dpb_engine_tb.sv
module dpb_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_528 = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic        cmd_end = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [7:0]  ld_data = 8'h00;
  logic        st_valid;
  logic        st_ready = 1'b0;
  logic [7:0]  st_data;
  logic [11:0] xfer_page;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_mem [0:1][0:527];

  always #5 clk = ~clk;

  dpb_engine dut_i (
    .clk(clk), .rst_n(rst_n), .page_528(page_528),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_end(cmd_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .xfer_page(xfer_page), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [23:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_addr = addr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_end();
    @(negedge clk); cmd_end = 1'b1;
    @(negedge clk); cmd_end = 1'b0;
  endtask

  task automatic push_wr(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_ld(input logic [7:0] b);
    @(negedge clk);
    ld_valid = 1'b1; ld_data = b;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pop_rd(output logic [7:0] b);
    @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge clk);
    b = rd_data;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pop_st(output logic [7:0] b);
    @(negedge clk);
    st_ready = 1'b1;
    while (!st_valid) @(negedge clk);
    b = st_data;
    @(negedge clk);
    st_ready = 1'b0;
  endtask

  // R5: page load of n bytes, pattern from seed
  task automatic load_page(input int bsel, input logic [11:0] pg, input int seed, input int n);
    logic [23:0] a;
    int bad = 0;
    a = page_528 ? {2'b00, pg, 10'h155} : {3'b000, pg, 9'h0AA};
    do_cmd(bsel != 0 ? 8'h55 : 8'h53, a);
    chk("R5 xfer_page", int'(xfer_page), int'(pg));
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((i * 7 + seed) & 255);
      push_ld(b);
      exp_mem[bsel][i] = b;
      if (i == 100) begin
        do_end();
        chk("R5 cmd_end ignored busy", int'(busy), 1);
      end
      if (i < n - 1 && !busy) bad++;
    end
    chk("R5 busy through load", bad, 0);
    chk("R5 idle after last byte", int'(busy), 0);
    chk("R5 ld_ready low after", int'(ld_ready), 0);
  endtask

  // R6: drain n bytes and compare with model
  task automatic store_page(input int bsel, input int n, input string req);
    int bad = 0;
    do_cmd(bsel != 0 ? 8'h86 : 8'h83, 24'h0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      pop_st(b);
      if (b !== exp_mem[bsel][i]) begin
        bad++;
        if (bad < 4) $display("FAIL %s: byte %0d actual %0h expected %0h", req, i, b, exp_mem[bsel][i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
    chk(req, int'(busy), 0);
  endtask

  task automatic write_run(input int bsel, input logic [23:0] addr, input int start,
                           input int n, input int seed, input int psz);
    int idx = start;
    do_cmd(bsel != 0 ? 8'h87 : 8'h84, addr);
    chk("R1 wr_ready open", int'(wr_ready), 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'((seed + k * 13) & 255);
      push_wr(b);
      exp_mem[bsel][idx] = b;
      idx = (idx == psz - 1) ? 0 : idx + 1;
    end
    do_end();
    chk("R8 idle after end", int'(cmd_ready), 1);
  endtask

  task automatic read_run(input int bsel, input bit fast, input logic [23:0] addr,
                          input int start, input int n, input int psz, input string req);
    int idx = start;
    int bad = 0;
    logic [7:0] op;
    op = fast ? (bsel != 0 ? 8'hD6 : 8'hD4) : (bsel != 0 ? 8'hD3 : 8'hD1);
    do_cmd(op, addr);
    if (fast) begin
      chk("R2 no data before dummy", int'(rd_valid), 0);
      @(negedge clk);
      chk("R2 still waiting dummy", int'(rd_valid), 0);
      push_wr(8'hEE);
      chk("R2 data after dummy", int'(rd_valid), 1);
    end else begin
      chk("R2 slow data at once", int'(rd_valid), 1);
    end
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      pop_rd(b);
      if (b !== exp_mem[bsel][idx]) begin
        bad++;
        $display("FAIL %s: index %0d actual %0h expected %0h", req, idx, b, exp_mem[bsel][idx]);
      end
      idx = (idx == psz - 1) ? 0 : idx + 1;
    end
    checks++;
    if (bad != 0) errors++;
    do_end();
    chk("R8 idle after read end", int'(cmd_ready), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 cmd_ready", int'(cmd_ready), 1);
    chk("R9 busy", int'(busy), 0);
    chk("R9 streams idle", int'({wr_ready, rd_valid, ld_ready, st_valid}), 0);

    // 528-byte mode
    page_528 = 1'b1;
    load_page(0, 12'hA5C, 3, 528);
    load_page(1, 12'h123, 7, 528);
    store_page(0, 528, "R5 other buffer untouched / R6 store A");
    store_page(1, 528, "R6 store B");

    // R1 R4: write across the wrap point, high don't-care bits set (R3)
    write_run(0, {14'h3FFF, 10'd520}, 520, 16, 5, 528);
    // R3: start 1000 -> 472
    write_run(1, {14'h2AAA, 10'd1000}, 472, 8, 9, 528);
    read_run(0, 1'b0, {14'h1234, 10'd520}, 520, 16, 528, "R4 wrap read 528");
    read_run(1, 1'b1, {14'h0, 10'd1000}, 472, 8, 528, "R3 start reduce");

    // R7: other opcodes do nothing
    foreach (exp_mem[0][i]) ;
    begin
      logic [7:0] nops [5] = '{8'hD2, 8'hE8, 8'h03, 8'h0B, 8'h9F};
      for (int i = 0; i < 5; i++) begin
        do_cmd(nops[i], 24'hFFFFFF);
        chk("R7 idle after other opcode", int'(cmd_ready && !busy), 1);
      end
    end
    store_page(0, 528, "R7 buffer A unchanged");
    store_page(1, 528, "R7 buffer B unchanged");

    // 512-byte mode
    page_528 = 1'b0;
    write_run(0, {15'h7FFF, 9'd500}, 500, 20, 33, 512);
    read_run(0, 1'b1, {15'h7FFF, 9'd500}, 500, 20, 512, "R4 wrap read 512");
    load_page(1, 12'h0F1, 9, 512);
    store_page(1, 512, "R6 store 512");
    store_page(0, 512, "R6 store A 512");
    read_run(1, 1'b0, {15'h4000, 9'd510}, 510, 4, 512, "R3 512 start");
    write_run(1, {15'h0001, 9'd0}, 0, 3, 77, 512);
    read_run(1, 1'b0, 24'h000200, 0, 3, 512, "R1 write B 512");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule